// File: doc/BRIEF.md
# Audio Decoder Control Register Target

This block is the control port of a TV multichannel audio decoder. It sits on a two-wire serial bus as a byte-oriented target. An external controller uses it to set the decoder's trims, volumes and mode switches, and to read back one status byte built from the decoder's detector flags. SDA and SCL are sampled with a much faster system clock. SDA is driven only as an open-drain pull-down enable.

A write transaction has three parts. The controller sends the write address, then a sub-address byte, then any number of data bytes. Each data byte lands in the register the pointer currently names, and the pointer then moves on by one. A read transaction returns the status byte. That byte carries a sticky power-on flag, which clears once it has been reported. The register fields are available as parallel outputs at all times.

Top module: `tvdec_ctrl_i2c`

## Requirements
- R1: After reset the fields hold level trim 9, high-band trim 0x1F, low-band trim 0x1F, volume left 0x3F, volume right 0x3F and unmute 1. Every other mode bit resets to 0.
- R2: The 8-bit address byte 0x84 (7-bit address 0x42, R/W bit 0) is acknowledged. Any address byte other than 0x84 and 0x85 gets no acknowledge. The block then ignores the rest of that transaction and changes no register.
- R3: In a write, the byte after the address sets the pointer, and the next data byte is stored at that pointer. The register layout is as follows. Sub-address 0 holds the level trim in bits 3:0. Sub-addresses 1 and 2 hold the high-band and low-band separation trims in bits 5:0. Sub-address 3 holds the mode byte: bit0 sap_sel, bit1 force_mono, bit2 unmute, bit3 sap_force, bit4 aux_sel, bit5 dac_test and bit6 bpf_monitor. Sub-addresses 4 and 5 hold volume left and volume right in bits 5:0. Bits outside these fields are dropped.
- R4: Each stored data byte advances the pointer by one, so a burst fills consecutive registers.
- R5: Data bytes aimed at sub-addresses 6 and above are acknowledged but discarded. The pointer stops counting once it passes 5 and never wraps back to 0.
- R6: The address byte 0x85 is acknowledged. The block then shifts out, MSB first, a status byte laid out as bit7 power-on flag, bit6 stereo_det, bit5 sap_det, bit4 noise_det and bits 3:0 zero. The flags are sampled when each byte starts.
- R7: The power-on flag is set by reset and clears once a status byte has been shifted out. It never sets again until the next reset.
- R8: If the controller acknowledges a status byte, a fresh status byte follows. If it does not acknowledge, SDA stays released until the next START or STOP.
- R9: A repeated START at any point begins a new address phase. The pointer keeps no state from the cut-off transfer except what the new transfer loads.
- R10: A STOP in the middle of a data byte discards the partial byte and leaves every register unchanged.
- R11: SDA is pulled low only in an acknowledge slot or for a zero status bit. The pull changes only while SCL is low, and it is off during reset and while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| stereo_det | input | 1 | Pilot detector flag |
| sap_det | input | 1 | Second-program carrier detector flag |
| noise_det | input | 1 | Second-program noise detector flag |
| lvl_trim | output | LVL_W | Input level trim |
| hf_sep_trim | output | TRIM_W | High-band separation trim |
| lf_sep_trim | output | TRIM_W | Low-band separation trim |
| vol_left | output | VOL_W | Left output volume |
| vol_right | output | VOL_W | Right output volume |
| sap_sel | output | 1 | Route the second program to the noise reducer |
| force_mono | output | 1 | Forced mono |
| unmute | output | 1 | 1 = outputs audible, 0 = muted |
| sap_force | output | 1 | Select the second program even without carrier detect |
| aux_sel | output | 1 | External input instead of decoder |
| dac_test | output | 1 | Trim DAC test mode |
| bpf_monitor | output | 1 | Band-pass filter monitor mode |

## Verification
The checker watches four properties on every cycle. The SDA pull and the register fields only move while SCL is low. A store never targets a sub-address past 5. The power-on flag never reasserts. No pull or store happens while the block is idle or waiting out a foreign transaction. The bench's scenarios are needed for everything else. That covers the register layout and masking, auto-increment bursts, pointer saturation, status byte contents and the flag clearing across reads, behaviour on acknowledge and no-acknowledge, repeated START and an aborted byte. Each of these shows only as a sequence of bus bytes.

// File: rtl/tvdec_ctrl_pkg.sv
package tvdec_ctrl_pkg;

   localparam int TDC_NREGS = 6;

   // register indices; order matters because the pointer walks them
   localparam int RI_LVL  = 0;
   localparam int RI_HF   = 1;
   localparam int RI_LF   = 2;
   localparam int RI_MODE = 3;
   localparam int RI_VOLL = 4;
   localparam int RI_VOLR = 5;

   // bit positions inside the mode byte
   localparam int MB_SAP_SEL   = 0;
   localparam int MB_MONO      = 1;
   localparam int MB_UNMUTE    = 2;
   localparam int MB_SAP_FORCE = 3;
   localparam int MB_AUX       = 4;
   localparam int MB_DAC_TEST  = 5;
   localparam int MB_BPF_MON   = 6;

   localparam logic [7:0] MODE_MASK  = 8'h7F;
   localparam logic [7:0] MODE_RESET = 8'(1 << MB_UNMUTE);

   typedef enum logic [2:0] {
      S_IDLE,
      S_RX,
      S_RX_END,
      S_ACK,
      S_TX,
      S_MACK,
      S_WAIT
   } tdc_state_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_SUB,
      PH_DATA
   } tdc_phase_e;

endpackage

// File: rtl/tdc_line_sync.sv
module tdc_line_sync #(
   parameter int               WIDTH    = 2,
   parameter int               STAGES   = 2,
   parameter logic [WIDTH-1:0] IDLE_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tdc_line_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_VAL;
         q_prev <= IDLE_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         q_prev <= chain[STAGES-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tdc_byte_engine.sv
module tdc_byte_engine
   import tvdec_ctrl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h42
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_ev,
   input  logic       stop_ev,
   input  logic       sda_s,
   input  logic [7:0] status_byte,
   output logic       sda_pull,
   output logic       wr_en,
   output logic [7:0] wr_idx,
   output logic [7:0] wr_data,
   output logic       st_sent,
   output logic       quiet
);

   localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};
   localparam logic [7:0] RD_BYTE = {DEV_ADDR, 1'b1};

   tdc_state_e state_q, state_d;
   tdc_phase_e phase_q, phase_d;
   logic       rd_q, rd_d;
   logic [2:0] cnt_q, cnt_d;
   logic [7:0] sh_q, sh_d;
   logic [7:0] ptr_q, ptr_d;
   logic       mack_q, mack_d;
   logic       in_range;

   assign in_range = (ptr_q < 8'(TDC_NREGS));

   always_comb begin
      state_d = state_q;
      phase_d = phase_q;
      rd_d    = rd_q;
      cnt_d   = cnt_q;
      sh_d    = sh_q;
      ptr_d   = ptr_q;
      mack_d  = mack_q;
      wr_en   = 1'b0;
      st_sent = 1'b0;
      if (stop_ev) begin
         state_d = S_IDLE;
      end else if (start_ev) begin
         state_d = S_RX;
         phase_d = PH_ADDR;
         cnt_d   = 3'd0;
      end else begin
         unique case (state_q)
            S_IDLE, S_WAIT: ;
            S_RX: begin
               if (scl_rise) begin
                  sh_d  = {sh_q[6:0], sda_s};
                  cnt_d = cnt_q + 3'd1;
                  if (cnt_q == 3'd7) state_d = S_RX_END;
               end
            end
            S_RX_END: begin
               if (scl_fall) begin
                  unique case (phase_q)
                     PH_ADDR: begin
                        if (sh_q == WR_BYTE) begin
                           state_d = S_ACK;
                           rd_d    = 1'b0;
                           phase_d = PH_SUB;
                        end else if (sh_q == RD_BYTE) begin
                           state_d = S_ACK;
                           rd_d    = 1'b1;
                        end else begin
                           state_d = S_WAIT;
                        end
                     end
                     PH_SUB: begin
                        ptr_d   = sh_q;
                        phase_d = PH_DATA;
                        state_d = S_ACK;
                     end
                     default: begin
                        wr_en   = in_range;
                        if (in_range) ptr_d = ptr_q + 8'd1;
                        state_d = S_ACK;
                     end
                  endcase
               end
            end
            S_ACK: begin
               if (scl_fall) begin
                  cnt_d = 3'd0;
                  if (rd_q) begin
                     state_d = S_TX;
                     sh_d    = status_byte;
                  end else begin
                     state_d = S_RX;
                  end
               end
            end
            S_TX: begin
               if (scl_fall) begin
                  if (cnt_q == 3'd7) begin
                     state_d = S_MACK;
                     st_sent = 1'b1;
                  end else begin
                     sh_d  = {sh_q[6:0], 1'b0};
                     cnt_d = cnt_q + 3'd1;
                  end
               end
            end
            default: begin
               if (scl_rise) begin
                  mack_d = !sda_s;
               end else if (scl_fall) begin
                  if (mack_q) begin
                     state_d = S_TX;
                     sh_d    = status_byte;
                     cnt_d   = 3'd0;
                  end else begin
                     state_d = S_WAIT;
                  end
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         phase_q  <= PH_ADDR;
         rd_q     <= 1'b0;
         cnt_q    <= 3'd0;
         sh_q     <= 8'd0;
         ptr_q    <= 8'd0;
         mack_q   <= 1'b0;
         sda_pull <= 1'b0;
      end else begin
         state_q  <= state_d;
         phase_q  <= phase_d;
         rd_q     <= rd_d;
         cnt_q    <= cnt_d;
         sh_q     <= sh_d;
         ptr_q    <= ptr_d;
         mack_q   <= mack_d;
         sda_pull <= (state_d == S_ACK) || ((state_d == S_TX) && !sh_d[7]);
      end
   end

   assign wr_idx  = ptr_q;
   assign wr_data = sh_q;
   assign quiet   = (state_q == S_IDLE) || (state_q == S_WAIT);

endmodule

// File: rtl/tdc_regbank.sv
module tdc_regbank
   import tvdec_ctrl_pkg::*;
#(
   parameter int LVL_W    = 4,
   parameter int TRIM_W   = 6,
   parameter int VOL_W    = 6,
   parameter int LVL_RST  = 9,
   parameter int TRIM_RST = 31,
   parameter int VOL_RST  = 63
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [7:0]             wr_idx,
   input  logic [7:0]             wr_data,
   input  logic                   st_sent,
   input  logic                   stereo_det,
   input  logic                   sap_det,
   input  logic                   noise_det,
   output logic [8*TDC_NREGS-1:0] bank_flat,
   output logic [7:0]             status_byte,
   output logic                   ponres
);

   function automatic logic [7:0] width_mask(int w);
      return 8'((1 << w) - 1);
   endfunction

   function automatic logic [7:0] reg_mask(int idx);
      case (idx)
         RI_LVL:        return width_mask(LVL_W);
         RI_HF, RI_LF:  return width_mask(TRIM_W);
         RI_MODE:       return MODE_MASK;
         default:       return width_mask(VOL_W);
      endcase
   endfunction

   function automatic logic [7:0] reg_reset(int idx);
      case (idx)
         RI_LVL:        return 8'(LVL_RST) & reg_mask(idx);
         RI_HF, RI_LF:  return 8'(TRIM_RST) & reg_mask(idx);
         RI_MODE:       return MODE_RESET;
         default:       return 8'(VOL_RST) & reg_mask(idx);
      endcase
   endfunction

   generate
      for (genvar gi = 0; gi < TDC_NREGS; gi++) begin : g_byte
         localparam logic [7:0] RV = reg_reset(gi);
         localparam logic [7:0] MK = reg_mask(gi);
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            q <= RV;
            else if (wr_en && wr_idx == 8'(gi))    q <= wr_data & MK;
         end
         assign bank_flat[gi*8 +: 8] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ponres <= 1'b1;
      else if (st_sent) ponres <= 1'b0;
   end

   assign status_byte = {ponres, stereo_det, sap_det, noise_det, 4'b0000};

endmodule

// File: rtl/tvdec_ctrl_i2c.sv
module tvdec_ctrl_i2c
   import tvdec_ctrl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h42,
   parameter int         SYNC_STAGES = 2,
   parameter int         LVL_W       = 4,
   parameter int         TRIM_W      = 6,
   parameter int         VOL_W       = 6,
   parameter int         LVL_RST     = 9,
   parameter int         TRIM_RST    = 31,
   parameter int         VOL_RST     = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull,
   input  logic              stereo_det,
   input  logic              sap_det,
   input  logic              noise_det,
   output logic [LVL_W-1:0]  lvl_trim,
   output logic [TRIM_W-1:0] hf_sep_trim,
   output logic [TRIM_W-1:0] lf_sep_trim,
   output logic [VOL_W-1:0]  vol_left,
   output logic [VOL_W-1:0]  vol_right,
   output logic              sap_sel,
   output logic              force_mono,
   output logic              unmute,
   output logic              sap_force,
   output logic              aux_sel,
   output logic              dac_test,
   output logic              bpf_monitor
);

   generate
      if (LVL_W < 1 || LVL_W > 8 || TRIM_W < 1 || TRIM_W > 8 || VOL_W < 1 || VOL_W > 8) begin : g_bad_w
         $error("field widths must lie in 1..8");
      end
      if (LVL_RST >= (1 << LVL_W) || TRIM_RST >= (1 << TRIM_W) || VOL_RST >= (1 << VOL_W)) begin : g_bad_rst
         $error("reset value does not fit its field");
      end
   endgenerate

   localparam int FIELD_W = LVL_W + 2*TRIM_W + 2*VOL_W + 7;

   logic [1:0] ln_s, ln_p;
   logic       scl_s, sda_s, scl_p, sda_p;
   logic       scl_rise, scl_fall, start_ev, stop_ev;
   logic       wr_en, st_sent, bus_quiet, ponres;
   logic [7:0] wr_idx, wr_data, status_byte;
   logic [8*TDC_NREGS-1:0] bank_flat;
   logic [7:0] mode_byte;
   logic [63:0] field_vec;
   logic       bits_unused;

   tdc_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .IDLE_VAL(2'b11)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      ({scl_i, sda_i}),
      .q      (ln_s),
      .q_prev (ln_p)
   );

   assign scl_s    = ln_s[1];
   assign sda_s    = ln_s[0];
   assign scl_p    = ln_p[1];
   assign sda_p    = ln_p[0];
   assign scl_rise = scl_s && !scl_p;
   assign scl_fall = !scl_s && scl_p;
   assign start_ev = scl_s && scl_p && sda_p && !sda_s;
   assign stop_ev  = scl_s && scl_p && !sda_p && sda_s;

   tdc_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_ev    (start_ev),
      .stop_ev     (stop_ev),
      .sda_s       (sda_s),
      .status_byte (status_byte),
      .sda_pull    (sda_pull),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .st_sent     (st_sent),
      .quiet       (bus_quiet)
   );

   tdc_regbank #(
      .LVL_W(LVL_W), .TRIM_W(TRIM_W), .VOL_W(VOL_W),
      .LVL_RST(LVL_RST), .TRIM_RST(TRIM_RST), .VOL_RST(VOL_RST)
   ) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .st_sent     (st_sent),
      .stereo_det  (stereo_det),
      .sap_det     (sap_det),
      .noise_det   (noise_det),
      .bank_flat   (bank_flat),
      .status_byte (status_byte),
      .ponres      (ponres)
   );

   assign lvl_trim    = bank_flat[RI_LVL*8 +: LVL_W];
   assign hf_sep_trim = bank_flat[RI_HF*8 +: TRIM_W];
   assign lf_sep_trim = bank_flat[RI_LF*8 +: TRIM_W];
   assign vol_left    = bank_flat[RI_VOLL*8 +: VOL_W];
   assign vol_right   = bank_flat[RI_VOLR*8 +: VOL_W];
   assign mode_byte   = bank_flat[RI_MODE*8 +: 8];

   assign sap_sel     = mode_byte[MB_SAP_SEL];
   assign force_mono  = mode_byte[MB_MONO];
   assign unmute      = mode_byte[MB_UNMUTE];
   assign sap_force   = mode_byte[MB_SAP_FORCE];
   assign aux_sel     = mode_byte[MB_AUX];
   assign dac_test    = mode_byte[MB_DAC_TEST];
   assign bpf_monitor = mode_byte[MB_BPF_MON];

   assign field_vec   = 64'({lvl_trim, hf_sep_trim, lf_sep_trim, vol_left, vol_right, mode_byte[6:0]});
   assign bits_unused = ^{bank_flat, mode_byte[7], field_vec, FIELD_W[0]};

endmodule

// File: rtl/tvdec_ctrl_i2c_chk.sv
module tvdec_ctrl_i2c_chk #(
   parameter int NREGS = 6
) (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_i,
   input logic        sda_pull,
   input logic [63:0] fields,
   input logic        ponres,
   input logic        quiet,
   input logic        wr_en,
   input logic [7:0]  wr_idx
);

   // R11: the pull may only move while the clock line is low
   a_r11_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_i);

   // R3: stored fields only update while the clock line is low
   a_r3_fields_move_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fields) |-> !scl_i);

   // R5: a store never targets a sub-address past the last register
   a_r5_store_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx < 8'(NREGS)));

   // R7: power-on flag never reasserts after reset
   a_r7_ponres_no_reassert: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> !$rose(ponres));

   // R8: idle or waiting means SDA released
   a_r8_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |-> !sda_pull);

   // R2: no store while idle or ignoring a foreign transaction
   a_r2_quiet_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |-> !wr_en);

endmodule

bind tvdec_ctrl_i2c tvdec_ctrl_i2c_chk #(.NREGS(6)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .sda_pull (sda_pull),
   .fields   (field_vec),
   .ponres   (ponres),
   .quiet    (bus_quiet),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx)
);

// File: tb/tb_tvdec_ctrl_i2c.sv
`timescale 1ns/1ps
module tb_tvdec_ctrl_i2c;

   localparam int Q = 10;  // quarter SCL period in system clocks
   localparam logic [7:0] MASKV [6] = '{8'h0F, 8'h3F, 8'h3F, 8'h7F, 8'h3F, 8'h3F};
   localparam logic [7:0] DEFV  [6] = '{8'h09, 8'h1F, 8'h1F, 8'h04, 8'h3F, 8'h3F};
   // {sub-address, data} single-byte writes
   localparam logic [15:0] VEC [8] = '{16'h00F3, 16'h01C5, 16'h022A, 16'h03FF,
                                       16'h0400, 16'h0515, 16'h030A, 16'h000C};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_low_m = 1'b0;
   logic stereo = 1'b0, sap = 1'b0, noise = 1'b0;
   logic sda_pull, sda_bus;
   logic [3:0] lvl_trim;
   logic [5:0] hf_sep_trim, lf_sep_trim, vol_left, vol_right;
   logic sap_sel, force_mono, unmute, sap_force, aux_sel, dac_test, bpf_monitor;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [7:0] exp_reg [6];
   logic [7:0] wbuf [8];

   always #10 clk = ~clk;

   assign sda_bus = !(sda_low_m || sda_pull);

   tvdec_ctrl_i2c dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull(sda_pull),
      .stereo_det(stereo), .sap_det(sap), .noise_det(noise),
      .lvl_trim(lvl_trim), .hf_sep_trim(hf_sep_trim), .lf_sep_trim(lf_sep_trim),
      .vol_left(vol_left), .vol_right(vol_right),
      .sap_sel(sap_sel), .force_mono(force_mono), .unmute(unmute), .sap_force(sap_force),
      .aux_sel(aux_sel), .dac_test(dac_test), .bpf_monitor(bpf_monitor)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] get_reg(input int i);
      case (i)
         0: return 8'(lvl_trim);
         1: return 8'(hf_sep_trim);
         2: return 8'(lf_sep_trim);
         3: return {1'b0, bpf_monitor, dac_test, aux_sel, sap_force, unmute, force_mono, sap_sel};
         4: return 8'(vol_left);
         default: return 8'(vol_right);
      endcase
   endfunction

   task automatic check_regs(input string tag);
      logic [47:0] g, e;
      for (int i = 0; i < 6; i++) begin
         g[8*(5-i) +: 8] = get_reg(i);
         e[8*(5-i) +: 8] = exp_reg[i];
      end
      check(g == e, tag, 64'(g), 64'(e));
   endtask

   task automatic i2c_start;
      sda_low_m = 1'b0; tick(Q);
      scl_m = 1'b1;     tick(Q);
      sda_low_m = 1'b1; tick(Q);
      scl_m = 1'b0;     tick(Q);
   endtask

   task automatic i2c_stop;
      sda_low_m = 1'b1; tick(Q);
      scl_m = 1'b1;     tick(Q);
      sda_low_m = 1'b0; tick(2*Q);
   endtask

   task automatic i2c_wbit(input logic b);
      sda_low_m = !b; tick(Q);
      scl_m = 1'b1;   tick(2*Q);
      scl_m = 1'b0;   tick(Q);
   endtask

   task automatic i2c_rbit(output logic b);
      sda_low_m = 1'b0; tick(Q);
      scl_m = 1'b1;     tick(Q);
      b = sda_bus;      tick(Q);
      scl_m = 1'b0;     tick(Q);
   endtask

   task automatic i2c_wbyte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) i2c_wbit(v[i]);
      i2c_rbit(b);
      ack = !b;
   endtask

   task automatic i2c_rbyte(input logic mack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         i2c_rbit(b);
         v[i] = b;
      end
      i2c_wbit(!mack);
   endtask

   // full write transaction with a model of the saturating pointer
   task automatic wr_burst(input logic [7:0] sub, input int n, output int nacks);
      logic a;
      int p;
      nacks = 0;
      i2c_start;
      i2c_wbyte(8'h84, a); if (!a) nacks++;
      i2c_wbyte(sub, a);   if (!a) nacks++;
      p = int'(sub);
      for (int k = 0; k < n; k++) begin
         i2c_wbyte(wbuf[k], a);
         if (!a) nacks++;
         if (p < 6) begin
            exp_reg[p] = wbuf[k] & MASKV[p];
            p++;
         end
      end
      i2c_stop;
   endtask

   initial begin
      logic a, b;
      logic [7:0] d;
      int nk;
      for (int i = 0; i < 6; i++) exp_reg[i] = DEFV[i];
      stereo = 1'b1; sap = 1'b0; noise = 1'b1;
      tick(5);
      check(sda_pull == 1'b0, "R11 pull off in reset", 64'(sda_pull), 64'd0);
      rst_n = 1'b1;
      tick(5);
      check_regs("R1 reset defaults");

      // R6 R7 R8: status reads, power-on flag, master ack then nack
      i2c_start;
      i2c_wbyte(8'h85, a);
      check(a, "R6 read address ack", 64'(a), 64'd1);
      i2c_rbyte(1'b1, d);
      check(d == 8'hD0, "R6 R7 first status byte", 64'(d), 64'hD0);
      i2c_rbyte(1'b0, d);
      check(d == 8'h50, "R7 R8 flag cleared in second byte", 64'(d), 64'h50);
      i2c_rbit(b);
      check(b == 1'b1, "R8 SDA released after nack", 64'(b), 64'd1);
      i2c_stop;
      check(sda_pull == 1'b0, "R11 released when idle", 64'(sda_pull), 64'd0);

      // R3: vector table of single-byte writes
      for (int v = 0; v < 8; v++) begin
         wbuf[0] = VEC[v][7:0];
         wr_burst(VEC[v][15:8], 1, nk);
         check(nk == 0, "R3 write acknowledged", 64'(nk), 64'd0);
         check_regs("R3 field layout and masking");
      end

      // R4: burst across all registers, seventh byte past the end
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
      wbuf[4] = 8'h55; wbuf[5] = 8'h66; wbuf[6] = 8'h77;
      wr_burst(8'h00, 7, nk);
      check(nk == 0, "R4 R5 burst all acked", 64'(nk), 64'd0);
      check_regs("R4 auto-increment burst");

      // R5: no wrap from the last register, out-of-range sub-address
      wbuf[0] = 8'h07; wbuf[1] = 8'h3C;
      wr_burst(8'h05, 2, nk);
      check(nk == 0, "R5 overrun byte acked", 64'(nk), 64'd0);
      check_regs("R5 pointer saturates, register 0 kept");
      wbuf[0] = 8'h2B;
      wr_burst(8'h09, 1, nk);
      check(nk == 0, "R5 high sub-address acked", 64'(nk), 64'd0);
      check_regs("R5 high sub-address discarded");

      // R2: foreign address
      i2c_start;
      i2c_wbyte(8'h90, a);
      check(!a, "R2 foreign address not acked", 64'(a), 64'd0);
      i2c_wbyte(8'h00, a);
      check(!a, "R2 later byte not acked", 64'(a), 64'd0);
      i2c_wbyte(8'h35, a);
      i2c_stop;
      check_regs("R2 registers untouched");

      // R9: repeated start into a new write
      i2c_start;
      i2c_wbyte(8'h84, a);
      i2c_wbyte(8'h01, a);
      i2c_start;
      i2c_wbyte(8'h84, a);
      i2c_wbyte(8'h02, a);
      i2c_wbyte(8'h11, a);
      i2c_stop;
      exp_reg[2] = 8'h11;
      check_regs("R9 repeated start write");

      // R9 R6: repeated start into a read with new flags
      stereo = 1'b0; sap = 1'b1; noise = 1'b1;
      i2c_start;
      i2c_wbyte(8'h84, a);
      i2c_wbyte(8'h04, a);
      i2c_start;
      i2c_wbyte(8'h85, a);
      check(a, "R9 read after repeated start acked", 64'(a), 64'd1);
      i2c_rbyte(1'b0, d);
      check(d == 8'h30, "R9 R6 live status after repeated start", 64'(d), 64'h30);
      i2c_stop;
      check_regs("R9 no write from sub-address only");

      stereo = 1'b0; sap = 1'b1; noise = 1'b0;
      i2c_start;
      i2c_wbyte(8'h85, a);
      i2c_rbyte(1'b0, d);
      i2c_stop;
      check(d == 8'h20, "R6 second-program flag alone", 64'(d), 64'h20);

      // R10: stop in the middle of a data byte
      i2c_start;
      i2c_wbyte(8'h84, a);
      i2c_wbyte(8'h00, a);
      i2c_wbit(1'b1); i2c_wbit(1'b0); i2c_wbit(1'b1); i2c_wbit(1'b0);
      i2c_stop;
      check_regs("R10 partial byte discarded");
      wbuf[0] = 8'h06;
      wr_burst(8'h00, 1, nk);
      check_regs("R10 recovery write");

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired got=0 exp=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule